// File: doc/BRIEF.md
# Two-Level Data Address Translator

This block turns 48-bit virtual data addresses into 40-bit physical addresses using two levels of cached translations. A small fully associative first level is searched in the same cycle as the request, so a hit costs nothing extra. On a first-level miss the request is held and a second level is searched. That level has a set-associative array for 4K, 16K and 64K pages and a separate fully associative array for 2M and 1G pages. Its answer arrives a fixed number of cycles later and is also copied into the first level.

When neither level holds the page, the block raises a walk request that carries the held virtual address. It keeps that request up until an external page walker presents a fill. The fill gives the physical page number and the page size. The block writes the fill into the array that matches the size, copies it into the first level, and answers the request in that same cycle. A flush input invalidates every entry in both levels and drops any request in progress.

Only one request is in flight at a time. A new request is accepted only while `reqReady` is high.

Top module: `dtlb_two_level`

## Requirements
- R1: In a cycle where `reqReady` and `reqValid` are high and the address hits the first level, `respValid` is high in that same cycle. `respPa` then holds the stored page number above the page offset and the request address below it.
- R2: A first-level miss that hits the second level raises `respValid` exactly MISS_LAT (default 5) cycles after the request cycle, and `reqReady` stays low until then.
- R3: Page sizes are encoded on `fillSize` as 0=4K, 1=16K, 2=64K, 3=2M, 4=1G, with offsets of 12, 14, 16, 21 and 30 bits. The set-associative array takes only codes 0 to 2. Its 8-bit set index is the address bits just above the page offset (bits 12, 14 or 16 upward), and its tag is the bits above the index. Any address inside a stored page translates to that page.
- R4: Fills with code 3 or 4 go to the large-page array. Any address inside such a page hits with the offset width of its size.
- R5: When both levels miss, `walkReq` rises MISS_LAT+1 cycles after the request cycle. It stays high with `walkVa` equal to the request address until `fillValid` is presented. `respValid` is high in the cycle of the fill, with `respPa` formed from `fillPpn`, `fillSize` and the request offset, and `walkReq` is low in the next cycle.
- R6: After a fill, a later request to the same page that misses the first level is answered from the second level without a walk.
- R7: Every answer from the second level or from a fill is copied into the first level, so the next request to that page hits with zero latency. First-level victims are taken in rotating order.
- R8: While `flushAll` is high, `reqReady` and `respValid` are low. After a flush, every page must be walked again.
- R9: After reset, `reqReady` is 1 and `respValid` and `walkReq` are 0.
- R10: A fill presented while no walk is pending is ignored: a following request to that page still walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Invalidate all entries and abort any request in progress |
| reqValid | input | 1 | Translation request valid |
| reqVa | input | 48 | Virtual address of the request |
| reqReady | output | 1 | Block can accept a request |
| respValid | output | 1 | Translation result valid |
| respPa | output | 40 | Physical address result |
| walkReq | output | 1 | Miss in all structures, walker needed |
| walkVa | output | 48 | Virtual address that needs walking |
| fillValid | input | 1 | Walker fill valid |
| fillVa | input | 48 | Virtual address the fill belongs to |
| fillSize | input | 3 | Page size code of the fill |
| fillPpn | input | 28 | Physical page number (address bits 39:12) |

## Verification
The hardest case to reach is a second-level hit. Every walk and every second-level hit also fills the first level, so a page normally keeps hitting at zero latency. The stimulus first walks one page of each of the five sizes. It then walks 48 unrelated 4K pages, which rotates the first-level victim pointer through every slot and evicts the five pages. After that, each of the five is requested again at an offset deep inside the page, which exercises the five-cycle path and the size-dependent index and tag selection.

// File: rtl/dtlb_pkg.sv
`timescale 1ns/1ps
package dtlb_pkg;

  typedef enum logic [2:0] {
    PG_4K  = 3'd0,
    PG_16K = 3'd1,
    PG_64K = 3'd2,
    PG_2M  = 3'd3,
    PG_1G  = 3'd4
  } pgSize_e;

  typedef enum logic [1:0] {
    SRC_MICRO = 2'd0,
    SRC_LVL   = 2'd1,
    SRC_FILL  = 2'd2
  } respSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       probe;
    logic [2:0] probeSize;
    logic       uRefill;
    logic       fillWrite;
    logic       flush;
    respSrc_e   src;
  } tlbCtl_t;

  function automatic int offBits(input logic [2:0] sz);
    case (sz)
      3'd0:    return 12;
      3'd1:    return 14;
      3'd2:    return 16;
      3'd3:    return 21;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
  import dtlb_pkg::*;
#(
  parameter int MISS_LAT = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    flushAll,
  input  logic    reqValid,
  input  logic    fillValid,
  input  logic    uHit,
  input  logic    lvlHit,
  output logic    reqReady,
  output logic    respValid,
  output logic    walkReq,
  output tlbCtl_t ctl
);
  localparam int CNT_W = $clog2(MISS_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WALK} state_e;
  state_e state, nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt       = state;
    reqReady  = 1'b0;
    respValid = 1'b0;
    ctl       = '0;
    ctl.flush = flushAll;
    ctl.src   = SRC_MICRO;
    case (state)
      S_IDLE: begin
        reqReady = !flushAll;
        if (reqValid) begin
          if (uHit) begin
            respValid = 1'b1;
          end else begin
            ctl.capture = 1'b1;
            nxt = S_LOOK;
          end
        end
      end
      S_LOOK: begin
        ctl.probe     = (cnt < CNT_W'(3));
        ctl.probeSize = 3'(cnt);
        if (cnt == CNT_W'(MISS_LAT - 1)) begin
          if (lvlHit) begin
            respValid   = 1'b1;
            ctl.src     = SRC_LVL;
            ctl.uRefill = 1'b1;
            nxt = S_IDLE;
          end else begin
            nxt = S_WALK;
          end
        end
      end
      S_WALK: begin
        if (fillValid) begin
          respValid     = 1'b1;
          ctl.src       = SRC_FILL;
          ctl.fillWrite = 1'b1;
          ctl.uRefill   = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (flushAll) begin
      nxt           = S_IDLE;
      respValid     = 1'b0;
      ctl.capture   = 1'b0;
      ctl.uRefill   = 1'b0;
      ctl.fillWrite = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (state == S_LOOK) ? cnt + 1'b1 : '0;
    end
  end

  assign walkReq = (state == S_WALK);

  // R5: a pending walk is kept until a fill or flush ends it
  a_r5_walk_held: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && !fillValid && !flushAll |=> walkReq);

  // R8: a flush leaves no walk pending
  a_r8_flush_drops_walk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !walkReq);

endmodule

// File: rtl/tlb_datapath.sv
`timescale 1ns/1ps
module tlb_datapath
  import dtlb_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 40,
  parameter int PG_OFF    = 12,
  parameter int U_ENTRIES = 48,
  parameter int M_SETS    = 256,
  parameter int M_WAYS    = 4,
  parameter int L_ENTRIES = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tlbCtl_t                    ctl,
  input  logic [VA_W-1:0]            reqVa,
  input  logic [VA_W-1:0]            fillVa,
  input  logic [2:0]                 fillSize,
  input  logic [PA_W-PG_OFF-1:0]     fillPpn,
  output logic                       uHit,
  output logic                       lvlHit,
  output logic [PA_W-1:0]            respPa,
  output logic [VA_W-1:0]            heldVa
);
  localparam int VPN_W   = VA_W - PG_OFF;
  localparam int PPN_W   = PA_W - PG_OFF;
  localparam int IDX_W   = $clog2(M_SETS);
  localparam int TAG_W   = VPN_W - IDX_W;
  localparam int U_PTR_W = $clog2(U_ENTRIES);
  localparam int L_PTR_W = $clog2(L_ENTRIES);
  localparam int W_PTR_W = (M_WAYS > 1) ? $clog2(M_WAYS) : 1;

  function automatic logic [VPN_W-1:0] ignMask(input logic [2:0] sz);
    return ~({VPN_W{1'b1}} << (offBits(sz) - PG_OFF));
  endfunction

  function automatic logic [PA_W-1:0] mkPa(input logic [VA_W-1:0] va,
      input logic [PPN_W-1:0] ppn, input logic [2:0] sz);
    logic [PA_W-1:0] m;
    m = ~({PA_W{1'b1}} << offBits(sz));
    return ({ppn, {PG_OFF{1'b0}}} & ~m) | (PA_W'(va) & m);
  endfunction

  logic [VPN_W-1:0] reqVpn, heldVpn;
  assign reqVpn  = VPN_W'(reqVa >> PG_OFF);
  assign heldVpn = VPN_W'(heldVa >> PG_OFF);

  always_ff @(posedge clk) begin
    if (!rstN) heldVa <= '0;
    else if (ctl.capture) heldVa <= reqVa;
  end

  // ---------------- first level ----------------
  logic [U_ENTRIES-1:0] uValid, uMatch;
  logic [2:0]           uSize [U_ENTRIES];
  logic [VPN_W-1:0]     uVpn  [U_ENTRIES];
  logic [PPN_W-1:0]     uPpn  [U_ENTRIES];
  logic [U_PTR_W-1:0]   uPtr;
  logic [PPN_W-1:0]     uSelPpn;
  logic [2:0]           uSelSize;

  for (genvar i = 0; i < U_ENTRIES; i++) begin : g_umatch
    assign uMatch[i] = uValid[i] && (((reqVpn ^ uVpn[i]) & ~ignMask(uSize[i])) == '0);
  end

  always_comb begin
    uSelPpn  = '0;
    uSelSize = '0;
    for (int i = U_ENTRIES - 1; i >= 0; i--) begin
      if (uMatch[i]) begin
        uSelPpn  = uPpn[i];
        uSelSize = uSize[i];
      end
    end
  end
  assign uHit = |uMatch;

  // ---------------- latched second-level result ----------------
  logic             hitR;
  logic [PPN_W-1:0] hitPpn;
  logic [2:0]       hitSize;
  logic [PPN_W-1:0] refPpn;
  logic [2:0]       refSize;

  assign refPpn  = (ctl.src == SRC_FILL) ? fillPpn  : hitPpn;
  assign refSize = (ctl.src == SRC_FILL) ? fillSize : hitSize;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      uValid <= '0;
      uPtr   <= '0;
    end else if (ctl.uRefill) begin
      uValid[uPtr] <= 1'b1;
      uPtr <= (uPtr == U_PTR_W'(U_ENTRIES - 1)) ? '0 : uPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.uRefill) begin
      uVpn[uPtr]  <= heldVpn;
      uPpn[uPtr]  <= refPpn;
      uSize[uPtr] <= refSize;
    end
  end

  // ---------------- set-associative small-page array ----------------
  logic [M_WAYS-1:0] mValid [M_SETS];
  logic [TAG_W-1:0]  mTag   [M_SETS][M_WAYS];
  logic [PPN_W-1:0]  mPpn   [M_SETS][M_WAYS];
  logic [2:0]        mSize  [M_SETS][M_WAYS];
  logic [W_PTR_W-1:0] mWayPtr;
  logic [IDX_W-1:0]  pIdx, fIdx;
  logic [TAG_W-1:0]  pTag, fTag;
  logic              mHit, fillLarge;
  logic [PPN_W-1:0]  mSelPpn;
  int                pSh, fSh;

  assign pSh  = offBits(ctl.probeSize) - PG_OFF;
  assign fSh  = offBits(fillSize) - PG_OFF;
  assign pIdx = IDX_W'(heldVa >> (PG_OFF + pSh));
  assign pTag = TAG_W'(heldVa >> (PG_OFF + IDX_W + pSh));
  assign fIdx = IDX_W'(fillVa >> (PG_OFF + fSh));
  assign fTag = TAG_W'(fillVa >> (PG_OFF + IDX_W + fSh));
  assign fillLarge = (fillSize > 3'd2);

  always_comb begin
    mHit    = 1'b0;
    mSelPpn = '0;
    for (int w = 0; w < M_WAYS; w++) begin
      if (mValid[pIdx][w] && mTag[pIdx][w] == pTag &&
          mSize[pIdx][w] == ctl.probeSize && !mHit) begin
        mHit    = 1'b1;
        mSelPpn = mPpn[pIdx][w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      for (int s = 0; s < M_SETS; s++) mValid[s] <= '0;
      mWayPtr <= '0;
    end else if (ctl.fillWrite && !fillLarge) begin
      mValid[fIdx][mWayPtr] <= 1'b1;
      mWayPtr <= (mWayPtr == W_PTR_W'(M_WAYS - 1)) ? '0 : mWayPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillWrite && !fillLarge) begin
      mTag[fIdx][mWayPtr]  <= fTag;
      mPpn[fIdx][mWayPtr]  <= fillPpn;
      mSize[fIdx][mWayPtr] <= fillSize;
    end
  end

  // ---------------- large-page array ----------------
  logic [L_ENTRIES-1:0] lValid, lMatch;
  logic [2:0]           lSize [L_ENTRIES];
  logic [VPN_W-1:0]     lVpn  [L_ENTRIES];
  logic [PPN_W-1:0]     lPpn  [L_ENTRIES];
  logic [L_PTR_W-1:0]   lPtr;
  logic [PPN_W-1:0]     lSelPpn;
  logic [2:0]           lSelSize;

  for (genvar i = 0; i < L_ENTRIES; i++) begin : g_lmatch
    assign lMatch[i] = lValid[i] && (((heldVpn ^ lVpn[i]) & ~ignMask(lSize[i])) == '0);
  end

  always_comb begin
    lSelPpn  = '0;
    lSelSize = '0;
    for (int i = L_ENTRIES - 1; i >= 0; i--) begin
      if (lMatch[i]) begin
        lSelPpn  = lPpn[i];
        lSelSize = lSize[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      lValid <= '0;
      lPtr   <= '0;
    end else if (ctl.fillWrite && fillLarge) begin
      lValid[lPtr] <= 1'b1;
      lPtr <= (lPtr == L_PTR_W'(L_ENTRIES - 1)) ? '0 : lPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillWrite && fillLarge) begin
      lVpn[lPtr]  <= VPN_W'(fillVa >> PG_OFF);
      lPpn[lPtr]  <= fillPpn;
      lSize[lPtr] <= fillSize;
    end
  end

  // ---------------- probe result latch ----------------
  always_ff @(posedge clk) begin
    if (!rstN || ctl.capture) begin
      hitR    <= 1'b0;
      hitPpn  <= '0;
      hitSize <= '0;
    end else if (ctl.probe && !hitR) begin
      if (mHit) begin
        hitR    <= 1'b1;
        hitPpn  <= mSelPpn;
        hitSize <= ctl.probeSize;
      end else if (|lMatch) begin
        hitR    <= 1'b1;
        hitPpn  <= lSelPpn;
        hitSize <= lSelSize;
      end
    end
  end
  assign lvlHit = hitR;

  always_comb begin
    case (ctl.src)
      SRC_LVL:  respPa = mkPa(heldVa, hitPpn, hitSize);
      SRC_FILL: respPa = mkPa(heldVa, fillPpn, fillSize);
      default:  respPa = mkPa(reqVa, uSelPpn, uSelSize);
    endcase
  end

  // R7: refills never create two first-level entries for one address
  a_r7_micro_unique: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(uMatch));

  // R4: a large-page fill never lands in the small-page array
  a_r4_large_not_in_main: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillWrite && fillLarge |=> $stable(mWayPtr));

endmodule

// File: rtl/dtlb_two_level.sv
`timescale 1ns/1ps
module dtlb_two_level
  import dtlb_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 40,
  parameter int PG_OFF    = 12,
  parameter int U_ENTRIES = 48,
  parameter int M_SETS    = 256,
  parameter int M_WAYS    = 4,
  parameter int L_ENTRIES = 128,
  parameter int MISS_LAT  = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flushAll,
  input  logic                   reqValid,
  input  logic [VA_W-1:0]        reqVa,
  output logic                   reqReady,
  output logic                   respValid,
  output logic [PA_W-1:0]        respPa,
  output logic                   walkReq,
  output logic [VA_W-1:0]        walkVa,
  input  logic                   fillValid,
  input  logic [VA_W-1:0]        fillVa,
  input  logic [2:0]             fillSize,
  input  logic [PA_W-PG_OFF-1:0] fillPpn
);
  tlbCtl_t ctl;
  logic    uHit, lvlHit;

  tlb_ctrl #(.MISS_LAT(MISS_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .fillValid(fillValid), .uHit(uHit), .lvlHit(lvlHit),
    .reqReady(reqReady), .respValid(respValid), .walkReq(walkReq), .ctl(ctl)
  );

  tlb_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_OFF(PG_OFF), .U_ENTRIES(U_ENTRIES),
    .M_SETS(M_SETS), .M_WAYS(M_WAYS), .L_ENTRIES(L_ENTRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqVa(reqVa), .fillVa(fillVa),
    .fillSize(fillSize), .fillPpn(fillPpn), .uHit(uHit), .lvlHit(lvlHit),
    .respPa(respPa), .heldVa(walkVa)
  );

  // Cycles since a request missed the first level
  logic [15:0] missAge;
  always_ff @(posedge clk) begin
    if (!rstN || flushAll) missAge <= '0;
    else if (reqValid && reqReady && !respValid) missAge <= 16'd1;
    else if (missAge != '0 && missAge != 16'hFFFF) missAge <= missAge + 16'd1;
  end

  // R2: a second-level answer arrives exactly MISS_LAT cycles after the request
  a_r2_level_latency: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !reqReady && !fillValid |-> missAge == 16'(MISS_LAT));

  // R5: the walk address stays put while the walk is pending
  a_r5_walkva_stable: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && $past(walkReq) |-> $stable(walkVa));

  // R1: a response while idle is always tied to a request in that cycle
  a_r1_resp_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    respValid && reqReady |-> reqValid);

endmodule

// File: tb/dtlb_two_level_tb.sv
`timescale 1ns/1ps
module dtlb_two_level_tb;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rstN, flushAll, reqValid, fillValid;
  logic [47:0] reqVa, fillVa, walkVa;
  logic [2:0]  fillSize;
  logic [27:0] fillPpn;
  logic        reqReady, respValid, walkReq;
  logic [39:0] respPa;

  always #4 clk = ~clk;

  dtlb_two_level u_dut (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .reqVa(reqVa), .reqReady(reqReady), .respValid(respValid), .respPa(respPa),
    .walkReq(walkReq), .walkVa(walkVa), .fillValid(fillValid), .fillVa(fillVa),
    .fillSize(fillSize), .fillPpn(fillPpn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0;
  int nFail = 0;

  typedef struct {
    logic [39:0] pa;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic logic [39:0] mkPa(input logic [47:0] va, input logic [27:0] ppn,
                                       input logic [2:0] sz);
    int off;
    logic [39:0] m;
    case (sz)
      3'd0: off = 12;
      3'd1: off = 14;
      3'd2: off = 16;
      3'd3: off = 21;
      default: off = 30;
    endcase
    m = ~({40{1'b1}} << off);
    return ({ppn, 12'h000} & ~m) | (va[39:0] & m);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  // Monitor: pops expected items as responses appear
  always begin
    @(negedge clk);
    #2;
    if (rstN === 1'b1 && respValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1", "unexpected response", {24'h0, respPa}, 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(respPa == e.pa, e.tag, "physical address", {24'h0, respPa}, {24'h0, e.pa});
        if (e.lat >= 0)
          chk((cyc - e.t0) == e.lat, e.tag, "latency", 64'(cyc - e.t0), 64'(e.lat));
      end
    end
  end

  // Driver: kind 0 = first-level hit, 1 = second-level hit, 2 = walk
  task automatic doReq(input logic [47:0] va, input int kind, input logic [27:0] ppn,
                       input logic [2:0] sz, input string rq);
    exp_t e;
    int n;
    @(negedge clk);
    reqValid = 1'b1;
    reqVa    = va;
    e.pa  = mkPa(va, ppn, sz);
    e.lat = (kind == 0) ? 0 : (kind == 1) ? LAT : -1;
    e.t0  = cyc;
    e.tag = rq;
    sb.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
    if (kind == 2) begin
      n = 1;
      while (!walkReq && n < 50) begin
        @(negedge clk);
        n++;
      end
      chk(n == LAT + 1, rq, "walk request cycle", 64'(n), 64'(LAT + 1));
      chk(walkVa == va, rq, "walk address", {16'h0, walkVa}, {16'h0, va});
      fillValid = 1'b1;
      fillVa    = va;
      fillPpn   = ppn;
      fillSize  = sz;
      @(negedge clk);
      fillValid = 1'b0;
      chk(!walkReq, "R5", "walk cleared after fill", 64'(walkReq), 64'h0);
    end else begin
      n = 0;
      while (!reqReady && n < 50) begin
        @(negedge clk);
        n++;
      end
    end
  endtask

  logic [47:0] pBase [5];
  logic [47:0] pOff  [5];
  logic [27:0] pPpn  [5];
  logic [2:0]  pSz   [5];
  string       pTag  [5];

  initial begin
    pBase[0] = 48'h1111_222F_0000; pOff[0] = 48'h123;       pPpn[0] = 28'hABC_DEF1; pSz[0] = 3'd0; pTag[0] = "R2,R3 4K";
    pBase[1] = 48'h2222_3333_C000; pOff[1] = 48'h2ABC;      pPpn[1] = 28'h123_4560; pSz[1] = 3'd1; pTag[1] = "R2,R3 16K";
    pBase[2] = 48'h3333_4444_0000; pOff[2] = 48'hF123;      pPpn[2] = 28'h0F0_F0F0; pSz[2] = 3'd2; pTag[2] = "R2,R3 64K";
    pBase[3] = 48'h4444_4020_0000; pOff[3] = 48'h1F_FFF0;   pPpn[3] = 28'h765_4200; pSz[3] = 3'd3; pTag[3] = "R2,R4 2M";
    pBase[4] = 48'h5555_4000_0000; pOff[4] = 48'h3FFF_FFFC; pPpn[4] = 28'h0C0_0000; pSz[4] = 3'd4; pTag[4] = "R2,R4 1G";

    rstN = 1'b0; flushAll = 1'b0; reqValid = 1'b0; fillValid = 1'b0;
    reqVa = '0; fillVa = '0; fillSize = '0; fillPpn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R9: reset state
    chk(reqReady == 1'b1, "R9", "reqReady after reset", 64'(reqReady), 64'h1);
    chk(respValid == 1'b0, "R9", "respValid after reset", 64'(respValid), 64'h0);
    chk(walkReq == 1'b0, "R9", "walkReq after reset", 64'(walkReq), 64'h0);

    // R5: walk each page size once
    for (int i = 0; i < 5; i++) doReq(pBase[i] + 48'h10, 2, pPpn[i], pSz[i], "R5");

    // R7: filled pages now hit the first level
    doReq(pBase[0] + 48'hFFF, 0, pPpn[0], pSz[0], "R7,R1");
    doReq(pBase[3] + 48'h1234, 0, pPpn[3], pSz[3], "R7,R1");

    // Rotate the first level through all its slots with unrelated 4K pages
    for (int i = 1; i <= 48; i++)
      doReq(48'h1000_0000_0000 + (48'(i) << 12), 2, 28'h800_0000 + 28'(i), 3'd0, "R5 filler");

    // R6: evicted pages come back from the second level, deep inside each page
    for (int i = 0; i < 5; i++) doReq(pBase[i] + pOff[i], 1, pPpn[i], pSz[i], pTag[i]);

    // R7: and are now back in the first level
    for (int i = 0; i < 5; i++) doReq(pBase[i] + (pOff[i] >> 1), 0, pPpn[i], pSz[i], "R7,R1");

    // R8: flush blocks the interface for its cycle
    @(negedge clk);
    flushAll = 1'b1;
    reqValid = 1'b1;
    reqVa    = pBase[0];
    #2;
    chk(respValid == 1'b0, "R8", "no response during flush", 64'(respValid), 64'h0);
    chk(reqReady == 1'b0, "R8", "not ready during flush", 64'(reqReady), 64'h0);
    @(negedge clk);
    flushAll = 1'b0;
    reqValid = 1'b0;
    // R8: every level was cleared, so both page kinds walk again
    doReq(pBase[0] + 48'h40, 2, pPpn[0], pSz[0], "R8");
    doReq(pBase[4] + 48'h40, 2, pPpn[4], pSz[4], "R8");

    // R10: a fill with no walk pending is dropped
    @(negedge clk);
    fillValid = 1'b1;
    fillVa    = 48'h6666_7777_8000;
    fillSize  = 3'd0;
    fillPpn   = 28'h111_1111;
    @(negedge clk);
    fillValid = 1'b0;
    doReq(48'h6666_7777_8000, 2, 28'h222_2222, 3'd0, "R10");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R1", "responses outstanding at end", 64'(sb.size()), 64'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule